// File: doc/BRIEF.md
# Usage-Bit Victim Selector

This block keeps the replacement state for a set-associative cache. Each set owns one usage bit per way. A way's bit is set whenever that way is touched, which includes a hit and a refill. When the touch that is about to land would leave every bit of the set at one, the whole set is zeroed instead. Each set is tracked on its own, and a touch to one set never disturbs another.

When the cache misses, it asks for a victim for the missing set. The block answers combinationally, in the same cycle. The answer is the lowest-numbered way whose usage bit is still zero. If a touch and a victim request name the same set in one cycle, the answer comes from the state before that cycle's update. The cache supplies the set index and way number of every touch, and it owns tags, data, hit detection and the write policy.

Top module: `plru_victim_sel`

## Requirements
- R1: After reset every usage bit of every set is zero, so a victim request to any set returns way 0.
- R2: A touch (accValid high) to way w of set s sets bit w of set s at the next clock edge, unless R3 applies.
- R3: When a touch would make every usage bit of its set one, all bits of that set become zero at that edge instead, so the next victim for that set is way 0.
- R4: The victim is the lowest-numbered way of the requested set whose usage bit is zero, and it is output as a binary way number on vicWay.
- R5: A touch to one set leaves the usage bits of every other set unchanged.
- R6: When a touch and a victim request address the same set in one cycle, the victim is taken from the bits held before that cycle's update.
- R7: vicValid is high exactly in the cycles where vicReq is high. vicWay is 0 while vicReq is low.
- R8: A touch to a way whose bit is already one leaves the set unchanged.
- R9: In a cycle with accValid low, no usage bit changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| accValid | input | 1 | Touch strobe (hit or refill) |
| accSet | input | $clog2(SETS) | Set index of the touch |
| accWay | input | $clog2(WAYS) | Way number of the touch |
| vicReq | input | 1 | Victim request strobe |
| vicSet | input | $clog2(SETS) | Set index of the victim request |
| vicWay | output | $clog2(WAYS) | Chosen victim way (same cycle) |
| vicValid | output | 1 | High when vicWay carries a victim |

## Verification
The assertions check the following on every cycle:
- The stored bits of the requested set are never all ones.
- The returned way's bit is zero.
- vicValid follows vicReq.
- When the previous victim was just touched and the state has not been cleared, the next victim moves to a higher way.

Only the bench scenarios can show the rest, using a reference model of every set:
- Progress through a full set, followed by the clear.
- Isolation between sets.
- The pre-update answer on a same-set collision.
- That repeated touches and idle cycles leave the state alone.

// File: rtl/plru_pkg.sv
package plru_pkg;

  // Strobes from the control half to the storage half.
  typedef struct packed {
    logic wrEn;    // write the touched set this cycle
    logic clrSet;  // write zeros instead of the merged bits
  } plruStrobe_t;

endpackage

// File: rtl/plru_first_zero.sv
module plru_first_zero #(
  parameter int WAYS = 4,
  localparam int WAYW = $clog2(WAYS)
) (
  input  logic [WAYS-1:0] usage,
  output logic [WAYW-1:0] idx,
  output logic            found
);

  // Priority encoder: the lowest zero wins, so scan from the top down.
  always_comb begin
    idx   = '0;
    found = 1'b0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!usage[i]) begin
        idx   = WAYW'(i);
        found = 1'b1;
      end
    end
  end

endmodule

// File: rtl/plru_ctrl.sv
module plru_ctrl
  import plru_pkg::*;
#(
  parameter int WAYS = 4,
  localparam int WAYW = $clog2(WAYS)
) (
  input  logic            accValid,
  input  logic [WAYW-1:0] accWay,
  input  logic [WAYS-1:0] accBits,
  output plruStrobe_t     strobe
);

  logic [WAYS-1:0] wayMask;
  logic [WAYS-1:0] merged;
  logic            alreadySet;

  always_comb begin
    wayMask         = '0;
    wayMask[accWay] = 1'b1;
  end

  assign merged     = accBits | wayMask;
  assign alreadySet = |(accBits & wayMask);

  // A touch to a way that is already set changes nothing, so no write.
  // A touch that fills the set writes zeros.
  always_comb begin
    strobe.wrEn   = accValid && !alreadySet;
    strobe.clrSet = accValid && !alreadySet && (&merged);
  end

endmodule

// File: rtl/plru_usage_store.sv
module plru_usage_store
  import plru_pkg::*;
#(
  parameter int WAYS = 4,
  parameter int SETS = 16,
  localparam int WAYW = $clog2(WAYS),
  localparam int SETW = $clog2(SETS)
) (
  input  logic            clk,
  input  logic            rstN,
  input  plruStrobe_t     strobe,
  input  logic [SETW-1:0] accSet,
  input  logic [WAYW-1:0] accWay,
  input  logic [SETW-1:0] vicSet,
  output logic [WAYS-1:0] accBits,
  output logic [WAYS-1:0] vicBits
);

  logic [WAYS-1:0] usageQ [SETS];
  logic [WAYS-1:0] wayMask;
  logic [WAYS-1:0] nextBits;

  always_comb begin
    wayMask         = '0;
    wayMask[accWay] = 1'b1;
  end

  assign nextBits = strobe.clrSet ? '0 : (accBits | wayMask);

  // One register row per set, each written only when the touch names it.
  for (genvar s = 0; s < SETS; s++) begin : g_set
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        usageQ[s] <= '0;
      end else if (strobe.wrEn && (accSet == SETW'(s))) begin
        usageQ[s] <= nextBits;
      end
    end
  end

  // Two read ports: one for the touch, one for the victim request.
  assign accBits = usageQ[accSet];
  assign vicBits = usageQ[vicSet];

endmodule

// File: rtl/plru_victim_sel.sv
module plru_victim_sel
  import plru_pkg::*;
#(
  parameter int WAYS = 4,
  parameter int SETS = 16,
  localparam int WAYW = $clog2(WAYS),
  localparam int SETW = $clog2(SETS)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            accValid,
  input  logic [SETW-1:0] accSet,
  input  logic [WAYW-1:0] accWay,
  input  logic            vicReq,
  input  logic [SETW-1:0] vicSet,
  output logic [WAYW-1:0] vicWay,
  output logic            vicValid
);

  plruStrobe_t     strobe;
  logic [WAYS-1:0] accBits;
  logic [WAYS-1:0] vicBits;
  logic [WAYW-1:0] zeroIdx;
  logic            zeroFound;

  plru_ctrl #(.WAYS(WAYS)) uCtrl (
    .accValid (accValid),
    .accWay   (accWay),
    .accBits  (accBits),
    .strobe   (strobe)
  );

  plru_usage_store #(.WAYS(WAYS), .SETS(SETS)) uStore (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .accSet  (accSet),
    .accWay  (accWay),
    .vicSet  (vicSet),
    .accBits (accBits),
    .vicBits (vicBits)
  );

  plru_first_zero #(.WAYS(WAYS)) uEnc (
    .usage (vicBits),
    .idx   (zeroIdx),
    .found (zeroFound)
  );

  assign vicWay   = vicReq ? zeroIdx : '0;
  assign vicValid = vicReq && zeroFound;

endmodule

// File: rtl/plru_victim_sel_chk.sv
module plru_victim_sel_chk #(
  parameter int WAYS = 4,
  parameter int SETS = 16,
  localparam int WAYW = $clog2(WAYS),
  localparam int SETW = $clog2(SETS)
) (
  input logic            clk,
  input logic            rstN,
  input logic            accValid,
  input logic [SETW-1:0] accSet,
  input logic [WAYW-1:0] accWay,
  input logic            vicReq,
  input logic [SETW-1:0] vicSet,
  input logic [WAYW-1:0] vicWay,
  input logic            vicValid,
  input logic [WAYS-1:0] vicBits
);

  AST_NEVER_FULL: assert property (@(posedge clk) disable iff (!rstN)
    vicBits != '1); // R3

  AST_VICTIM_IS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    vicReq |-> !vicBits[vicWay]); // R4

  AST_VALID_ON_REQ: assert property (@(posedge clk) disable iff (!rstN)
    vicReq |-> vicValid); // R7

  AST_IDLE_OUTPUTS: assert property (@(posedge clk) disable iff (!rstN)
    !vicReq |-> (!vicValid && vicWay == '0)); // R7

  AST_VICTIM_ADVANCES: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(accValid && vicReq && accSet == vicSet && accWay == vicWay)
      && vicReq && vicSet == $past(vicSet))
    |-> (vicWay > $past(vicWay) || vicWay == '0)); // R2

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(!accValid && vicReq) && vicReq && vicSet == $past(vicSet))
    |-> vicWay == $past(vicWay)); // R9

endmodule

bind plru_victim_sel plru_victim_sel_chk #(.WAYS(WAYS), .SETS(SETS)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .accValid (accValid),
  .accSet   (accSet),
  .accWay   (accWay),
  .vicReq   (vicReq),
  .vicSet   (vicSet),
  .vicWay   (vicWay),
  .vicValid (vicValid),
  .vicBits  (vicBits)
);

// File: tb/sim_plru_victim_sel.sv
module sim_plru_victim_sel;

  localparam int WAYS = 4;
  localparam int SETS = 16;
  localparam int WAYW = $clog2(WAYS);
  localparam int SETW = $clog2(SETS);

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            accValid = 1'b0;
  logic [SETW-1:0] accSet = '0;
  logic [WAYW-1:0] accWay = '0;
  logic            vicReq = 1'b0;
  logic [SETW-1:0] vicSet = '0;
  logic [WAYW-1:0] vicWay;
  logic            vicValid;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  logic [WAYS-1:0] model [SETS];

  always #5 clk = ~clk;

  plru_victim_sel #(.WAYS(WAYS), .SETS(SETS)) u0 (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accSet(accSet), .accWay(accWay),
    .vicReq(vicReq), .vicSet(vicSet), .vicWay(vicWay), .vicValid(vicValid)
  );

  function automatic int firstZero(input logic [WAYS-1:0] b);
    for (int i = 0; i < WAYS; i++) if (!b[i]) return i;
    return 0;
  endfunction

  function automatic logic [WAYS-1:0] touched(input logic [WAYS-1:0] b, input int w);
    logic [WAYS-1:0] n;
    n = b;
    n[w] = 1'b1;
    return (n == '1) ? '0 : n;
  endfunction

  // One cycle: drive after the falling edge, check before the rising edge,
  // then advance the model at the rising edge.
  task automatic step(input bit aV, input int aS, input int aW,
                      input bit vR, input int vS, input string req);
    int expWay;
    bit expValid;
    @(negedge clk);
    accValid = aV; accSet = SETW'(aS); accWay = WAYW'(aW);
    vicReq = vR; vicSet = SETW'(vS);
    #2;
    expValid = vR;
    expWay = vR ? firstZero(model[vS]) : 0;
    testsRun++;
    if (vicValid !== expValid || int'(vicWay) != expWay) begin
      testsFailed++;
      $display("FAIL %s: set %0d actual valid=%0b way=%0d expected valid=%0b way=%0d",
               req, vS, vicValid, vicWay, expValid, expWay);
    end
    @(posedge clk);
    if (aV) model[aS] = touched(model[aS], aW);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      testsFailed++;
      testsRun++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int s = 0; s < SETS; s++) model[s] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: reset state in every set
    for (int s = 0; s < SETS; s++) step(0, 0, 0, 1, s, "R1");

    // R7: no request gives low valid and way 0
    step(0, 0, 0, 0, 0, "R7");

    // R2/R4: fill set 3 in order, then R3 clear on the last way
    for (int w = 0; w < WAYS; w++) begin
      step(1, 3, w, 1, 3, "R2");
      step(0, 0, 0, 1, 3, (w == WAYS - 1) ? "R3" : "R4");
    end

    // R4: out-of-order touches leave a hole at a low way
    step(1, 7, 2, 0, 0, "R2");
    step(1, 7, 0, 1, 7, "R4");
    step(0, 0, 0, 1, 7, "R4");

    // R5: neighbours untouched
    step(0, 0, 0, 1, 6, "R5");
    step(0, 0, 0, 1, 8, "R5");

    // R8: repeat a set way, state unchanged
    step(1, 7, 2, 1, 7, "R8");
    step(0, 0, 0, 1, 7, "R8");

    // R9: idle cycles leave state alone
    step(0, 0, 0, 1, 7, "R9");
    step(0, 0, 0, 1, 7, "R9");

    // R6: collision uses pre-update bits, including the filling touch
    step(1, 9, 0, 1, 9, "R6");
    step(1, 9, 1, 1, 9, "R6");
    step(1, 9, 2, 1, 9, "R6");
    step(1, 9, 3, 1, 9, "R6");
    step(0, 0, 0, 1, 9, "R3");

    // Random mix across a few sets so fills and clears occur often
    for (int i = 0; i < 3000; i++) begin
      bit aV, vR;
      int aS, aW, vS;
      aV = ($urandom % 4) != 0;
      vR = ($urandom % 4) != 0;
      aS = $urandom % 4;
      aW = $urandom % WAYS;
      vS = (($urandom % 2) != 0) ? aS : ($urandom % 4);
      step(aV, aS, aW, vR, vS, "R4");
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule